// File: doc/BRIEF.md
# Word-over-byte bus access adapter

This adapter turns 16-bit register reads and writes from a controller into cycles on a peripheral bus. The peripheral bus is either 8 or 16 bits wide, fixed at build time by a parameter. Register offsets are byte addresses even though every request moves a full 16-bit word. On a 16-bit bus each word takes one bus cycle. On an 8-bit bus each word takes two byte cycles, at the offset and at the next byte address. A parameter chooses which half of the word goes in the first byte cycle, so the adapter matches hosts of either endianness.

Before it accepts its first request after reset, the adapter programs the peripheral's bus-width mode register at offset 0. It writes 0x0001 when the bus is 16 bits wide and 0x0000 when it is 8 bits wide.

The requester sees a simple interface. A request is a one-clock `req` pulse, and it is taken only while `ready` is high. Completion is signalled by a one-clock `ack`. For a read, `rd_valid` pulses in the same clock and `rd_data` holds the assembled word. Each bus cycle drives registered chip-select, write-enable, address and write data for one clock. The peripheral returns read data during that clock.

Top module: `word_byte_bridge`

## Requirements
- R1: After reset is released, and before any request is accepted, the adapter writes the mode word to offset 0. The mode word is 0x0001 for a 16-bit bus and 0x0000 for an 8-bit bus. On an 8-bit bus it is split like any other word. This write produces no `ack` and no `rd_valid`.
- R2: With a 16-bit bus, each accepted word produces exactly one bus cycle. That cycle uses `bus_addr` equal to `req_addr`, and for writes `bus_wdata` equal to `req_wdata`.
- R3: With an 8-bit bus, each accepted word produces two byte cycles in adjacent clocks. The first is at `req_addr` and the second at `req_addr`+1, taken modulo 2^ADDR_W. The two cycles are never interleaved with another request.
- R4: With an 8-bit bus and HOST_BIG_ENDIAN=0, the byte cycle at the offset carries bits [15:8] of the word and the cycle at offset+1 carries bits [7:0]. This applies to both writes and reads.
- R5: With an 8-bit bus and HOST_BIG_ENDIAN=1, the byte cycle at the offset carries bits [7:0] of the word and the cycle at offset+1 carries bits [15:8]. This applies to both writes and reads.
- R6: `bus_cs` is high for exactly one clock per bus cycle. It is low for at least one clock between consecutive words. `bus_addr`, `bus_we` and `bus_wdata` come from registers.
- R7: For a read, `rd_valid` is high for one clock, and only in a clock where `ack` is high. In that clock `rd_data` holds the word assembled from `bus_rdata` as sampled during the strobe clocks of that word.
- R8: Every accepted request gets exactly one `ack`, high for one clock, in the clock right after its last bus cycle. `rd_valid` stays low for writes.
- R9: `ready` is high only when no transfer, including the mode write, is in progress. A `req` pulse while `ready` is low is ignored: it causes no bus cycle and no `ack`.
- R10: While `rst_n` is low, `bus_cs`, `ack`, `rd_valid` and `ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-clock request pulse, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 16 | Word to write |
| ready | output | 1 | Adapter idle and able to take a request |
| ack | output | 1 | One-clock completion pulse per word |
| rd_valid | output | 1 | One-clock pulse marking valid read data |
| rd_data | output | 16 | Assembled read word |
| bus_cs | output | 1 | Peripheral chip-select strobe |
| bus_we | output | 1 | Peripheral write enable |
| bus_addr | output | ADDR_W | Peripheral byte address |
| bus_wdata | output | BUS_W | Peripheral write data |
| bus_rdata | input | BUS_W | Peripheral read data, valid during the strobe clock |

## Verification
The assertions assume that `req` is raised only as a one-clock pulse and that `bus_rdata` is settled within the clock in which `bus_cs` is high. The ignore rule for requests made while busy is checked separately from those assumptions. The stimulus always pulses `req` for a single clock and lets a peripheral model answer combinationally from its storage. It also deliberately drives extra `req` pulses while `ready` is low. Three builds are exercised: an 8-bit bus with each byte order and a 16-bit bus. Each build runs back-to-back requests issued in the `ack` clock, overlapping byte offsets and an address that wraps past the top.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_IDLE,
    ST_BEAT
  } wbb_state_e;

  // Word written to the peripheral's width register at offset 0.
  function automatic logic [15:0] bus_mode_word(input int unsigned bus_w);
    return (bus_w == 16) ? 16'h0001 : 16'h0000;
  endfunction

  // For an 8-bit bus: does the given beat carry the upper byte of the word?
  // Little-endian host: beat 0 upper. Big-endian host: beat 0 lower.
  function automatic logic beat_takes_high(input logic beat, input logic big_end);
    return beat ^ ~big_end;
  endfunction

  // Number of bus cycles per 16-bit word.
  function automatic int unsigned beats_per_word(input int unsigned bus_w);
    return 16 / bus_w;
  endfunction

endpackage

// File: rtl/wbb_lane_sel.sv
module wbb_lane_sel #(
  parameter int unsigned BUS_W   = 8,
  parameter bit          BIG_END = 1'b0
) (
  input  logic [15:0]      word,
  input  logic             beat,
  output logic [BUS_W-1:0] lane
);
  if (BUS_W == 16) begin : g_word
    logic beat_unused;
    assign beat_unused = beat;
    assign lane = word;
  end else begin : g_split
    logic upper;
    assign upper = wbb_pkg::beat_takes_high(beat, BIG_END);
    assign lane  = upper ? word[15:8] : word[7:0];
  end
endmodule

// File: rtl/wbb_assemble.sv
module wbb_assemble #(
  parameter int unsigned BUS_W   = 8,
  parameter bit          BIG_END = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_beat,
  input  logic [BUS_W-1:0] lane_in,
  output logic [15:0]      word
);
  if (BUS_W == 16) begin : g_word
    logic beat_unused;
    assign beat_unused = cap_beat;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word <= '0;
      else if (cap_en) word <= lane_in;
    end
  end else begin : g_split
    logic upper;
    assign upper = wbb_pkg::beat_takes_high(cap_beat, BIG_END);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word <= '0;
      end else if (cap_en) begin
        if (upper) word[15:8] <= lane_in;
        else       word[7:0]  <= lane_in;
      end
    end
  end
endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [BUS_W-1:0]  lane_wdata,
  output logic [15:0]       sel_word,
  output logic              sel_beat,
  output logic              ready,
  output logic              ack,
  output logic              rd_valid,
  output logic              cap_en,
  output logic              cap_beat,
  output logic              bus_cs,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata
);
  localparam int unsigned BEATS     = beats_per_word(BUS_W);
  localparam logic        LAST_BEAT = (BEATS == 2);
  localparam logic [15:0] MODE_WORD = bus_mode_word(BUS_W);

  wbb_state_e        state;
  logic              beat_q;
  logic              cur_we;
  logic [15:0]       cur_word;
  logic              cur_init;

  // Named internal events.
  logic accept, boot_go, strobe_end, beat_last, advance;
  assign accept     = (state == ST_IDLE) && req;
  assign boot_go    = (state == ST_BOOT);
  assign strobe_end = (state == ST_BEAT);
  assign beat_last  = (beat_q == LAST_BEAT);
  assign advance    = strobe_end && !beat_last;

  assign ready    = (state == ST_IDLE);
  assign sel_word = accept ? req_wdata : (boot_go ? MODE_WORD : cur_word);
  assign sel_beat = advance ? (beat_q + 1'b1) : 1'b0;
  assign cap_en   = strobe_end && !cur_we;
  assign cap_beat = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      beat_q    <= 1'b0;
      cur_we    <= 1'b0;
      cur_word  <= '0;
      cur_init  <= 1'b0;
      ack       <= 1'b0;
      rd_valid  <= 1'b0;
      bus_cs    <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      ack      <= 1'b0;
      rd_valid <= 1'b0;
      unique case (state)
        ST_BOOT: begin
          cur_we    <= 1'b1;
          cur_word  <= MODE_WORD;
          cur_init  <= 1'b1;
          beat_q    <= 1'b0;
          bus_cs    <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= '0;
          bus_wdata <= lane_wdata;
          state     <= ST_BEAT;
        end
        ST_IDLE: begin
          if (req) begin
            cur_we    <= req_we;
            cur_word  <= req_wdata;
            cur_init  <= 1'b0;
            beat_q    <= 1'b0;
            bus_cs    <= 1'b1;
            bus_we    <= req_we;
            bus_addr  <= req_addr;
            bus_wdata <= lane_wdata;
            state     <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (!beat_last) begin
            beat_q    <= beat_q + 1'b1;
            bus_addr  <= bus_addr + ADDR_W'(1);
            bus_wdata <= lane_wdata;
          end else begin
            bus_cs   <= 1'b0;
            bus_we   <= 1'b0;
            state    <= ST_IDLE;
            ack      <= !cur_init;
            rd_valid <= !cur_init && !cur_we;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The first strobe after reset is the mode write to offset 0.
  assert_init_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs) && cur_init) |-> (bus_we && bus_addr == '0));

  // A word's last strobe is followed by a deselected clock.
  assert_strobe_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && beat_last) |=> !bus_cs);

  // A new word on the bus only ever follows a request taken while ready.
  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs) && !cur_init) |-> $past(req && ready));

  // Completion comes right after a strobe, as a single pulse.
  assert_ack_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(bus_cs) && !bus_cs));
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // Read-valid only with ack and only after a read strobe.
  assert_rdv_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ack && !$past(bus_we)));

  if (BEATS == 2) begin : g_split_chk
    // Second byte cycle directly follows the first, one address higher.
    assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !beat_last) |=> (bus_cs && bus_addr == $past(bus_addr) + ADDR_W'(1)));
  end
endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge #(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned BUS_W           = 8,
  parameter bit          HOST_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              ready,
  output logic              ack,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              bus_cs,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata
);
  logic [15:0]      sel_word;
  logic             sel_beat;
  logic [BUS_W-1:0] lane_wdata;
  logic             cap_en;
  logic             cap_beat;

  wbb_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .lane_wdata (lane_wdata),
    .sel_word   (sel_word),
    .sel_beat   (sel_beat),
    .ready      (ready),
    .ack        (ack),
    .rd_valid   (rd_valid),
    .cap_en     (cap_en),
    .cap_beat   (cap_beat),
    .bus_cs     (bus_cs),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
  );

  wbb_lane_sel #(.BUS_W(BUS_W), .BIG_END(HOST_BIG_ENDIAN)) u_lane_sel (
    .word (sel_word),
    .beat (sel_beat),
    .lane (lane_wdata)
  );

  wbb_assemble #(.BUS_W(BUS_W), .BIG_END(HOST_BIG_ENDIAN)) u_assemble (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_beat (cap_beat),
    .lane_in  (bus_rdata),
    .word     (rd_data)
  );
endmodule

// File: tb/word_byte_bridge_harness.sv
`timescale 1ns/1ps
module word_byte_bridge_harness #(
  parameter int BUS_W   = 8,
  parameter bit BIG_END = 1'b0,
  parameter int SEED    = 1
) (
  input  logic clk,
  output int   compared,
  output int   mismatched,
  output logic done
);
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NB    = (BUS_W == 8) ? 2 : 1;
  localparam int BMASK = (1 << BUS_W) - 1;

  logic rst_n = 1'b1;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready, ack, rd_valid, bus_cs, bus_we;
  logic [15:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic [BUS_W-1:0] bus_wdata, bus_rdata;

  word_byte_bridge #(.ADDR_W(AW), .BUS_W(BUS_W), .HOST_BIG_ENDIAN(BIG_END)) u_word_byte_bridge (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .ack(ack), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Peripheral: storage answered within the strobe clock.
  logic [BUS_W-1:0] dev_mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dev_mem[i] <= BUS_W'(i * 37 + 11);
    end else if (bus_cs && bus_we) begin
      dev_mem[bus_addr] <= bus_wdata;
    end
  end
  assign bus_rdata = dev_mem[bus_addr];

  // Reference model: shadow of peripheral contents plus expected per-clock slots.
  typedef struct {
    bit cs; bit we; int addr; int wdata; bit ack; bit rdv; int rdata; int tag;
  } slot_t;
  slot_t q[$];
  int shadow [DEPTH];

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s (bus %0d be %0d): actual %0h expected %0h", tag, what, BUS_W, BIG_END, act, exp);
    end
  endtask

  // Push the bus cycles (and ack) one word must produce; keep shadow in step.
  task automatic push_word(input bit we, input int a, input int w, input bit init);
    int hi, lo, rd;
    hi = (w >> 8) & 255;
    lo = w & 255;
    for (int b = 0; b < NB; b++) begin
      slot_t s;
      s.cs = 1; s.we = we; s.ack = 0; s.rdv = 0; s.rdata = 0;
      s.addr = (a + b) % DEPTH;
      if (NB == 1) s.wdata = w;
      else if (BIG_END) s.wdata = (b == 0) ? lo : hi;   // R5 order
      else s.wdata = (b == 0) ? hi : lo;                // R4 order
      s.tag = init ? 1 : ((NB == 1) ? 2 : 3);
      if (we) shadow[s.addr] = s.wdata & BMASK;
      q.push_back(s);
    end
    if (NB == 1) rd = shadow[a];
    else if (BIG_END) rd = shadow[a] | (shadow[(a + 1) % DEPTH] << 8);
    else rd = (shadow[a] << 8) | shadow[(a + 1) % DEPTH];
    if (!init) begin
      slot_t k;
      k.cs = 0; k.we = 0; k.addr = 0; k.wdata = 0; k.tag = 0;
      k.ack = 1; k.rdv = !we; k.rdata = rd;
      q.push_back(k);
    end
  endtask

  task automatic step();
    slot_t e;
    string wtag;
    @(negedge clk);
    if (!rst_n) begin
      // R10: idle outputs during reset
      chk(int'(bus_cs), 0, "R10", "cs in reset");
      chk(int'(ack), 0, "R10", "ack in reset");
      chk(int'(rd_valid), 0, "R10", "rd_valid in reset");
      chk(int'(ready), 0, "R10", "ready in reset");
      return;
    end
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.cs = 0; e.we = 0; e.addr = 0; e.wdata = 0; e.ack = 0; e.rdv = 0; e.rdata = 0; e.tag = 0;
    end
    chk(int'(bus_cs), int'(e.cs), "R6", "bus_cs");
    if (e.cs && bus_cs) begin
      chk(int'(bus_we), int'(e.we), tag_name(e.tag), "bus_we");
      chk(int'(bus_addr), e.addr, tag_name(e.tag), "bus_addr");
      if (e.we) begin
        wtag = (e.tag == 1) ? "R1" : (NB == 1) ? "R2" : (BIG_END ? "R5" : "R4");
        chk(int'(bus_wdata), e.wdata, wtag, "bus_wdata");
      end
    end
    chk(int'(ack), int'(e.ack), "R8", "ack");
    chk(int'(rd_valid), int'(e.rdv), "R8", "rd_valid");
    if (e.rdv) chk(int'(rd_data), e.rdata, "R7", "rd_data");
    chk(int'(ready), int'(!e.cs), "R9", "ready");
  endtask

  // Issue one word; optionally pulse a request while busy (R9: must be dropped).
  task automatic issue(input bit we, input int a, input int w, input bit intrude);
    while (!ready) step();
    req = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = 16'(w);
    push_word(we, a, w, 1'b0);
    step();
    req = 1'b0;
    if (intrude) begin
      req = 1'b1; req_we = 1'b1; req_addr = AW'(a + 77); req_wdata = 16'hDEAD;
      step();
      req = 1'b0;
    end
  endtask

  initial begin
    int r;
    done = 1'b0; compared = 0; mismatched = 0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = (i * 37 + 11) & BMASK;
    r = int'($urandom(SEED));
    #1 rst_n = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    push_word(1'b1, 0, (BUS_W == 16) ? 1 : 0, 1'b1);   // R1 mode write
    issue(1'b0, 0, 0, 1'b0);                          // R1 read back
    issue(1'b1, 16, 16'hA1B2, 1'b0);                  // R2/R3/R4/R5 write
    issue(1'b0, 16, 0, 1'b0);                         // R7 read
    issue(1'b0, 17, 0, 1'b0);                         // overlapping offset
    issue(1'b1, 255, 16'h5AC3, 1'b1);                 // R3 wrap, R9 intruder
    issue(1'b0, 255, 0, 1'b1);
    issue(1'b0, 0, 0, 1'b0);
    for (int n = 0; n < 80; n++) begin
      issue(bit'($urandom % 2), int'($urandom % DEPTH), int'($urandom % 65536),
            bit'(($urandom % 4) == 0));
    end
    repeat (4) step();
    chk(q.size(), 0, "R8", "pending slots at end");
    done = 1'b1;
  end
endmodule

// File: tb/word_byte_bridge_bench.sv
`timescale 1ns/1ps
module word_byte_bridge_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int c0, m0, c1, m1, c2, m2;
  logic d0, d1, d2;

  word_byte_bridge_harness #(.BUS_W(8),  .BIG_END(1'b0), .SEED(11)) h_le  (.clk(clk), .compared(c0), .mismatched(m0), .done(d0));
  word_byte_bridge_harness #(.BUS_W(8),  .BIG_END(1'b1), .SEED(22)) h_be  (.clk(clk), .compared(c1), .mismatched(m1), .done(d1));
  word_byte_bridge_harness #(.BUS_W(16), .BIG_END(1'b0), .SEED(33)) h_w16 (.clk(clk), .compared(c2), .mismatched(m2), .done(d2));

  initial begin
    int cycles;
    int wd_fail;
    cycles = 0;
    wd_fail = 0;
    @(posedge clk);
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cycles < 50000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 50000) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion before %0d", cycles, 50000);
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", c0 + c1 + c2 + wd_fail, m0 + m1 + m2 + wd_fail);
    $finish;
  end
endmodule